// File: doc/BRIEF.md
# Byte-Access Clock Configuration Target

This block sits on a two-wire serial management bus as a target device. A host reaches a small bank of clock-configuration registers through it, one byte per transaction. A transaction starts with the 7-bit device address and a command byte. The top bit of the command byte marks a byte operation, and its low seven bits pick the register offset. A byte write then carries one data byte. A byte read turns the bus around with a repeated start and returns one byte.

Register 0 holds four frequency-select bits. Their reset value is taken from strap inputs. A software-override bit, clear at reset, gates them: while that bit is clear, the select outputs and reads follow the live straps and host writes to those bits are discarded. Register 1 holds the spread-spectrum controls and two output-enable bits. Register 2 holds a drive-strength bit and a third output enable. The enable outputs follow their register bits directly, with no extra flop in the path.

SCL and SDA are brought into the clock domain through a two-flop synchronizer. Start and stop are recognised as SDA edges while SCL is high. The target drives SDA only by pulling it low, and only while SCL is low.

Top module: `smb_cfg_slave`

## Requirements
- R1: A byte write has this order: start, address with bit 0 = 0, command, data, stop. Bits go MSB first. The target pulls SDA low in each of the three acknowledge slots. The data lands in the register at offset command[6:0]. The target changes SDA only while SCL is low.
- R2: A byte read has this order: start, address with bit 0 = 0, command, repeated start, address with bit 0 = 1. The target acknowledges all three bytes. It then drives the register at the commanded offset, MSB first, and releases SDA for the host's not-acknowledge.
- R3: An address other than DEV_ADDR gets no acknowledge. The target leaves SDA released until the next start, and no register changes.
- R4: A command byte with bit 7 = 0 is not acknowledged. The data byte that follows is ignored.
- R5: Register 0 bit 3 (override) resets to 0. While it is 0, writes to bits 6, 5, 4 and 1 are discarded. In that state, `fsel` and the read value of those bits follow the live straps: bit 6 = strap_fs[3], bit 5 = strap_fs[2], bit 4 = strap_fs[1], bit 1 = strap_fs[0].
- R6: Once the override bit is 1 from an earlier write, bits 6, 5, 4 and 1 take host writes and drive `fsel`. Until the first such write, they hold the strap value captured at reset.
- R7: Register 0 bit 7 reads 0, bit 2 reads strap_res and bit 0 reads strap_mode, whatever is written.
- R8: Register 1 resets to bits 7..1 = 0111110, and bit 0 reads strap_mult. The fields are: bit 7 spread_center (0 down, 1 center), bit 6 spread_en, bits 5:4 spread_bw, bit 3 clk_en_cpu_a, bit 2 clk_en_cpu_b, bit 1 pd_tristate.
- R9: Clearing an output-enable bit takes that enable output low as soon as the register holds the new value. This happens within the data-acknowledge slot, before the stop.
- R10: Register 2 resets to 0x60. Bit 7 is drive_boost (reset 0), bit 6 is clk_en_pci (reset 1), bit 5 reads 1, and bits 4:0 read 0.
- R11: Offsets 3 to 127 are acknowledged, read as 0x00 and ignore writes.
- R12: A start in any state aborts the transaction in progress and begins a new address phase. A stop returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; captures straps |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_fs | input | 4 | Frequency-select straps |
| strap_res | input | 1 | Strap reflected in register 0 bit 2 |
| strap_mode | input | 1 | Strap reflected in register 0 bit 0 |
| strap_mult | input | 1 | Strap reflected in register 1 bit 0 |
| fsel | output | 4 | Effective frequency select |
| spread_center | output | 1 | 1 center spread, 0 down spread |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_bw | output | 2 | Spread bandwidth select |
| clk_en_cpu_a | output | 1 | First CPU clock enable |
| clk_en_cpu_b | output | 1 | Second CPU clock enable |
| pd_tristate | output | 1 | Power-down output mode select |
| drive_boost | output | 1 | Raised drive strength for the PCI clock |
| clk_en_pci | output | 1 | PCI clock enable |

## Verification
The bench goes after the override ordering. If a design applied the select bits in the same write that sets the override bit, a read after that write would show the written bits and not the captured straps. If a design kept tracking straps after the override bit was cleared, the stored select value would come back wrong when the bit is set again. The bench drives a not-acknowledged address and a command without its byte-operation bit. A design that kept listening after either one would change register 1. A start driven in the middle of a byte must re-arm the address phase; a design that kept its bit count would lose alignment and fail to acknowledge. The bench samples the enable outputs inside the acknowledge slot, so an enable that waited for the stop would be caught.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] strap_fs,
  input  logic       strap_res,
  input  logic       strap_mode,
  input  logic       strap_mult,
  output logic [3:0] fsel,
  output logic       spread_center,
  output logic       spread_en,
  output logic [1:0] spread_bw,
  output logic       clk_en_cpu_a,
  output logic       clk_en_cpu_b,
  output logic       pd_tristate,
  output logic       drive_boost,
  output logic       clk_en_pci
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_DACK, S_RDAT, S_RACK, S_WAIT
  } st_t;

  st_t        st;
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [6:0] ofs;
  logic       rw, oe;

  logic       lock;
  logic [3:0] fs_sw;
  logic [7:1] r1;
  logic       r2_boost, r2_en;
  logic [7:0] rd_byte;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise      = scl_s & ~scl_d;
  wire fall      = ~scl_s & scl_d;
  wire byte_end  = fall && (cnt == 4'd8);
  wire wr_go     = (st == S_WDAT) && byte_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sh  <= '0;
      cnt <= '0;
      ofs <= '0;
      rw  <= 1'b0;
      oe  <= 1'b0;
    end else if (start_det) begin
      st  <= S_ADDR;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (stop_det) begin
      st  <= S_IDLE;
      oe  <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WDAT: begin
          if (rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                oe <= 1'b1;
                rw <= sh[0];
                st <= S_AACK;
              end else begin
                st <= S_WAIT;
              end
            end else if (st == S_CMD) begin
              if (sh[7]) begin
                oe  <= 1'b1;
                ofs <= sh[6:0];
                st  <= S_CACK;
              end else begin
                st <= S_WAIT;
              end
            end else begin
              oe <= 1'b1;
              st <= S_DACK;
            end
          end
        end
        S_AACK: if (fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= rd_byte;
            oe <= ~rd_byte[7];
            st <= S_RDAT;
          end else begin
            oe <= 1'b0;
            st <= S_CMD;
          end
        end
        S_CACK: if (fall) begin
          cnt <= '0;
          oe  <= 1'b0;
          st  <= S_WDAT;
        end
        S_DACK: if (fall) begin
          oe <= 1'b0;
          st <= S_WAIT;
        end
        S_RDAT: begin
          if (rise) cnt <= cnt + 4'd1;
          else if (byte_end) begin
            oe <= 1'b0;
            st <= S_RACK;
          end else if (fall) begin
            sh <= {sh[6:0], 1'b0};
            oe <= ~sh[6];
          end
        end
        S_RACK: if (rise) st <= S_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock     <= 1'b0;
      fs_sw    <= strap_fs;
      r1       <= 7'b0111110;
      r2_boost <= 1'b0;
      r2_en    <= 1'b1;
    end else if (wr_go) begin
      case (ofs)
        7'd0: begin
          if (lock) fs_sw <= {sh[6], sh[5], sh[4], sh[1]};
          lock <= sh[3];
        end
        7'd1: r1 <= sh[7:1];
        7'd2: begin
          r2_boost <= sh[7];
          r2_en    <= sh[6];
        end
        default: ;
      endcase
    end
  end

  assign fsel = lock ? fs_sw : strap_fs;

  always_comb begin
    case (ofs)
      7'd0:    rd_byte = {1'b0, fsel[3:1], lock, strap_res, fsel[0], strap_mode};
      7'd1:    rd_byte = {r1, strap_mult};
      7'd2:    rd_byte = {r2_boost, r2_en, 1'b1, 5'b0};
      default: rd_byte = 8'h00;
    endcase
  end

  assign sda_oe        = oe;
  assign spread_center = r1[7];
  assign spread_en     = r1[6];
  assign spread_bw     = r1[5:4];
  assign clk_en_cpu_a  = r1[3];
  assign clk_en_cpu_b  = r1[2];
  assign pd_tristate   = r1[1];
  assign drive_boost   = r2_boost;
  assign clk_en_pci    = r2_en;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe) || $fell(oe)) |-> !scl_s); // R1
  AST_BAD_ADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && byte_end && sh[7:1] != DEV_ADDR) |=> !oe); // R3
  AST_FS_HELD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> $stable(fs_sw)); // R5
  AST_R1_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(r1)); // R8
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && cnt == 4'd0 && !oe)); // R12

endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [3:0] strap_fs = 4'b1010;
  logic strap_res = 1'b1, strap_mode = 1'b0, strap_mult = 1'b1;
  logic sda_oe, spread_center, spread_en, clk_en_cpu_a, clk_en_cpu_b;
  logic pd_tristate, drive_boost, clk_en_pci;
  logic [3:0] fsel;
  logic [1:0] spread_bw;
  wire sda_line = sda_m & ~sda_oe;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  smb_cfg_slave #(.DEV_ADDR(ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_fs(strap_fs), .strap_res(strap_res), .strap_mode(strap_mode),
    .strap_mult(strap_mult), .fsel(fsel), .spread_center(spread_center),
    .spread_en(spread_en), .spread_bw(spread_bw), .clk_en_cpu_a(clk_en_cpu_a),
    .clk_en_cpu_b(clk_en_cpu_b), .pd_tristate(pd_tristate),
    .drive_boost(drive_boost), .clk_en_pci(clk_en_pci));

  // {write?, command, write data, expected read, requirement}
  localparam logic [28:0] VEC [11] = '{
    {1'b0, 8'h80, 8'h00, 8'h54, 4'd7},   // R7 reset view of reg 0
    {1'b1, 8'h80, 8'h72, 8'h54, 4'd5},   // R5 select bits ignored while unlocked
    {1'b0, 8'h81, 8'h00, 8'h7D, 4'd8},   // R8 reset of reg 1
    {1'b0, 8'h82, 8'h00, 8'h60, 4'd10},  // R10 reset of reg 2
    {1'b1, 8'h81, 8'hA3, 8'hA3, 4'd8},   // R8 write
    {1'b1, 8'h82, 8'hFF, 8'hE0, 4'd10},  // R10 fixed bits
    {1'b1, 8'h85, 8'hFF, 8'h00, 4'd11},  // R11 unimplemented offset
    {1'b1, 8'h80, 8'h08, 8'h5C, 4'd6},   // R6 lock keeps captured straps
    {1'b1, 8'h80, 8'hFF, 8'h7E, 4'd6},   // R6 software select
    {1'b1, 8'h80, 8'h00, 8'h54, 4'd5},   // R5 unlock shows straps
    {1'b1, 8'h80, 8'h08, 8'h0C, 4'd6}    // R6 stored value kept
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(1'b1);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    bus_start();
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(d);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [2:0] ak;
    logic [7:0] rd;
    logic a;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // reset state: R5 fsel from straps, R8/R10 enables, R3 SDA released
    chk(5, "reset fsel", {4'h0, fsel}, 8'h0A);
    chk(8, "reset reg1 outputs", {1'b0, spread_center, spread_en, spread_bw, clk_en_cpu_a, clk_en_cpu_b, pd_tristate}, 8'h3E);
    chk(10, "reset reg2 outputs", {6'h0, drive_boost, clk_en_pci}, 8'h01);
    chk(3, "reset sda_oe", {7'h0, sda_oe}, 8'h00);

    for (int k = 0; k < 11; k++) begin
      if (VEC[k][28]) begin
        wr_txn(ADDR, VEC[k][27:20], VEC[k][19:12], ak);
        chk(1, $sformatf("write acks row %0d", k), {5'h0, ak}, 8'h07);
      end
      rd_txn(VEC[k][27:20], rd, ak);
      chk(2, $sformatf("read acks row %0d", k), {5'h0, ak}, 8'h07);
      chk(int'(VEC[k][3:0]), $sformatf("read row %0d", k), rd, VEC[k][11:4]);
    end

    chk(6, "fsel from software", {4'h0, fsel}, 8'h00);
    chk(8, "reg1 outputs after write", {1'b0, spread_center, spread_en, spread_bw, clk_en_cpu_a, clk_en_cpu_b, pd_tristate}, 8'h51);
    chk(10, "reg2 outputs after write", {6'h0, drive_boost, clk_en_pci}, 8'h03);

    // R3 foreign address
    wr_txn(7'h22, 8'h81, 8'h7C, ak);
    chk(3, "foreign address acks", {5'h0, ak}, 8'h00);
    rd_txn(8'h81, rd, ak);
    chk(3, "reg1 after foreign write", rd, 8'hA3);

    // R4 command without byte-operation bit
    wr_txn(ADDR, 8'h01, 8'hFF, ak);
    chk(4, "bad command acks", {5'h0, ak}, 8'h04);
    rd_txn(8'h81, rd, ak);
    chk(4, "reg1 after bad command", rd, 8'hA3);

    // R9 enables follow inside the ack slot
    wr_txn(ADDR, 8'h81, 8'h7C, ak);
    chk(9, "enables set", {6'h0, clk_en_cpu_a, clk_en_cpu_b}, 8'h03);
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h81, a);
    send_byte(8'h74, a);
    chk(9, "enable a low before stop", {6'h0, clk_en_cpu_a, clk_en_cpu_b}, 8'h01);
    bus_stop();

    // R12 start in mid-byte re-arms the address phase
    bus_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({ADDR, 1'b0}, ak[2]);
    send_byte(8'h82, ak[1]);
    send_byte(8'h00, ak[0]);
    bus_stop();
    chk(12, "acks after aborted byte", {5'h0, ak}, 8'h07);
    rd_txn(8'h82, rd, ak);
    chk(12, "reg2 after re-armed write", rd, 8'h20);

    // R5/R7/R8 second reset with other straps
    strap_fs = 4'b0101; strap_res = 1'b0; strap_mode = 1'b1; strap_mult = 1'b0;
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk(5, "fsel after reset", {4'h0, fsel}, 8'h05);
    rd_txn(8'h80, rd, ak);
    chk(7, "reg0 after new straps", rd, 8'h23);
    rd_txn(8'h81, rd, ak);
    chk(8, "reg1 strap bit", rd, 8'h7C);
    strap_fs = 4'b1100;
    tick(2);
    chk(5, "fsel tracks live straps", {4'h0, fsel}, 8'h0C);
    rd_txn(8'h80, rd, ak);
    chk(5, "reg0 tracks live straps", rd, 8'h61);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule